// File: doc/BRIEF.md
# UART Mode-Change Sequencer

This block is a small register-bus master that reprograms the operating mode of an attached UART in a way that avoids a spurious transmit underrun inside the peripheral. A single start pulse carries two bytes: the new mode value and a FIFO-control value. The sequencer then runs a fixed series of bus transfers on its own. First it writes the mode byte. It then holds the bus idle for a guard interval long enough to cover several interconnect and UART functional clock cycles with a wide margin. Next it writes FIFO control with both flush bits forced on. Finally it polls the line status register until both FIFOs report empty.

Polling is bounded. Reads are spaced by a programmable gap, and the number of attempts is capped. If the cap is reached without an empty report, the sequencer raises a timeout flag and finishes anyway, so software is never stalled. Register addresses on the bus are register indices scaled by four.

Top module: `uart_mode_seq`

## Requirements
- R1: After an accepted start, the transfers appear in this order: a write to the mode register (index 0x08, byte address 0x20), a write to FIFO control (index 0x02, address 0x08), then one or more reads of line status (index 0x05, address 0x14). Every address is the index shifted left by two.
- R2: The FIFO-control request rises exactly GUARD_CYCLES clock edges after the edge at which the mode write is acknowledged.
- R3: The FIFO-control write data equals the supplied FIFO value ORed with 0x06: bit 1 clears the receive FIFO and bit 2 clears the transmit FIFO.
- R4: A status read ends polling successfully when bit 5 (transmitter empty) is 1 and bit 0 (receive data ready) is 0. The other bits are ignored.
- R5: The first status request rises one edge after the FIFO-control write is acknowledged. After a status read that is not empty, the next request rises POLL_GAP_CYCLES edges after that acknowledge.
- R6: At most MAX_POLLS status reads are made per sequence. If the last allowed read is still not empty, timeout_o is set and the sequence finishes.
- R7: timeout_o is cleared by an accepted start and otherwise holds its value between sequences.
- R8: busy_o rises the cycle after an accepted start. done_o is a single-cycle pulse, and busy_o is low in that same cycle.
- R9: A start that arrives while busy_o is high is ignored. The running sequence keeps its original values and no extra transfers follow.
- R10: Only one bus request is outstanding at a time. While bus_req_o is high and not yet acknowledged, address, direction and write data stay stable.
- R11: After reset, busy_o, done_o, timeout_o and bus_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_val_i | input | DATA_W | Mode byte written first |
| fifo_val_i | input | DATA_W | FIFO-control byte; flush bits are forced on |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| timeout_o | output | 1 | Polling ran out of attempts in the last sequence |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | ADDR_W | Byte address (index << REG_SHIFT) |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Acknowledge; the transfer completes at the edge where it is seen with the request |
| bus_rdata_i | input | DATA_W | Read data, valid together with the acknowledge |

## Verification
Every timing result is measured from the acknowledge edge of the preceding transfer. The FIFO-control request rises GUARD_CYCLES edges after that point. The first status request rises one edge after it. Each retry rises POLL_GAP_CYCLES edges after it. busy_o rises one cycle after start, and done_o comes in the cycle after the final acknowledge. The bench slave drives acknowledges on falling edges with a random delay of 0 to 3 cycles. It logs the falling-edge index at which each request is first seen and at which each acknowledge is given, so every gap is compared against its expected count plus the one-cycle offset that this half-cycle sampling adds. Result flags and transfer counts are read a few idle cycles after done_o, when nothing is still in flight.

// File: rtl/uart_mode_seq_pkg.sv
package uart_mode_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE_WR,
    ST_GUARD,
    ST_FIFO_WR,
    ST_GAP,
    ST_POLL_RD
  } seq_state_e;

  localparam int unsigned IDX_W = 6;

  // register indices and field positions
  localparam logic [IDX_W-1:0] IDX_MODE = 6'h08;
  localparam logic [IDX_W-1:0] IDX_FIFO = 6'h02;
  localparam logic [IDX_W-1:0] IDX_STAT = 6'h05;

  localparam int unsigned STAT_EMPTY_BIT = 5;
  localparam int unsigned STAT_DATA_BIT  = 0;
  localparam int unsigned FIFO_RXCLR_BIT = 1;
  localparam int unsigned FIFO_TXCLR_BIT = 2;

endpackage

// File: rtl/uart_mode_seq_timer.sv
module uart_mode_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/uart_mode_seq_busif.sv
module uart_mode_seq_busif #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rsp_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (cmd_i) begin
      req_q   <= 1'b1;
      we_q    <= cmd_we_i;
      addr_q  <= cmd_addr_i;
      wdata_q <= cmd_wdata_i;
    end
  end

  assign req_o      = req_q;
  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign rsp_o      = req_q & ack_i;
  assign rsp_data_o = rdata_i;

endmodule

// File: rtl/uart_mode_seq_ctrl.sv
module uart_mode_seq_ctrl
  import uart_mode_seq_pkg::*;
#(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned REG_SHIFT       = 2,
  parameter int unsigned GUARD_CYCLES    = 100,
  parameter int unsigned POLL_GAP_CYCLES = 50,
  parameter int unsigned MAX_POLLS       = 255,
  parameter int unsigned CNT_W           = 7,
  parameter int unsigned PC_W            = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mode_val_i,
  input  logic [DATA_W-1:0] fifo_val_i,
  input  logic              rsp_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              tmr_zero_i,
  output logic              cmd_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam logic [DATA_W-1:0] FLUSH_MASK =
    DATA_W'((1 << FIFO_RXCLR_BIT) | (1 << FIFO_TXCLR_BIT));
  localparam logic [DATA_W-1:0] STAT_MASK =
    DATA_W'((1 << STAT_EMPTY_BIT) | (1 << STAT_DATA_BIT));
  localparam logic [DATA_W-1:0] STAT_WANT = DATA_W'(1 << STAT_EMPTY_BIT);

  localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(IDX_MODE) << REG_SHIFT;
  localparam logic [ADDR_W-1:0] ADDR_FIFO = ADDR_W'(IDX_FIFO) << REG_SHIFT;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(IDX_STAT) << REG_SHIFT;

  seq_state_e        st_q, st_d;
  logic [DATA_W-1:0] fifo_q;
  logic [PC_W-1:0]   polls_q;
  logic              done_q, tmo_q;
  logic              stat_ok, last_poll;

  assign stat_ok   = (rsp_data_i & STAT_MASK) == STAT_WANT;
  assign last_poll = (polls_q == PC_W'(MAX_POLLS));

  always_comb begin
    st_d        = st_q;
    cmd_o       = 1'b0;
    cmd_we_o    = 1'b0;
    cmd_addr_o  = ADDR_STAT;
    cmd_wdata_o = '0;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        cmd_o       = 1'b1;
        cmd_we_o    = 1'b1;
        cmd_addr_o  = ADDR_MODE;
        cmd_wdata_o = mode_val_i;
        st_d        = ST_MODE_WR;
      end
      ST_MODE_WR: if (rsp_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(GUARD_CYCLES - 1);
        st_d       = ST_GUARD;
      end
      ST_GUARD: if (tmr_zero_i) begin
        cmd_o       = 1'b1;
        cmd_we_o    = 1'b1;
        cmd_addr_o  = ADDR_FIFO;
        cmd_wdata_o = fifo_q | FLUSH_MASK;
        st_d        = ST_FIFO_WR;
      end
      ST_FIFO_WR: if (rsp_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = '0;
        st_d       = ST_GAP;
      end
      ST_GAP: if (tmr_zero_i) begin
        cmd_o = 1'b1;
        st_d  = ST_POLL_RD;
      end
      ST_POLL_RD: if (rsp_i) begin
        if (stat_ok || last_poll) begin
          st_d = ST_IDLE;
        end else begin
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(POLL_GAP_CYCLES - 1);
          st_d       = ST_GAP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fifo_q  <= '0;
      polls_q <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      if (st_q == ST_IDLE && start_i) begin
        fifo_q <= fifo_val_i;
        tmo_q  <= 1'b0;
      end
      if (st_q == ST_FIFO_WR && rsp_i) polls_q <= '0;
      if (st_q == ST_GAP && tmr_zero_i) polls_q <= polls_q + 1'b1;
      if (st_q == ST_POLL_RD && rsp_i && (stat_ok || last_poll)) begin
        done_q <= 1'b1;
        tmo_q  <= ~stat_ok;
      end
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

endmodule

// File: rtl/uart_mode_seq.sv
module uart_mode_seq #(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned REG_SHIFT       = 2,
  parameter int unsigned GUARD_CYCLES    = 100,
  parameter int unsigned POLL_GAP_CYCLES = 50,
  parameter int unsigned MAX_POLLS       = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mode_val_i,
  input  logic [DATA_W-1:0] fifo_val_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  localparam int unsigned WAIT_MAX =
    (GUARD_CYCLES > POLL_GAP_CYCLES) ? GUARD_CYCLES : POLL_GAP_CYCLES;
  localparam int unsigned CNT_W = $clog2(WAIT_MAX + 1);
  localparam int unsigned PC_W  = $clog2(MAX_POLLS + 1);

  logic              cmd, cmd_we, rsp, tmr_load, tmr_zero;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, rsp_data;
  logic [CNT_W-1:0]  tmr_val;

  uart_mode_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_SHIFT(REG_SHIFT),
    .GUARD_CYCLES(GUARD_CYCLES), .POLL_GAP_CYCLES(POLL_GAP_CYCLES),
    .MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W), .PC_W(PC_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_val_i, .fifo_val_i,
    .rsp_i(rsp), .rsp_data_i(rsp_data), .tmr_zero_i(tmr_zero),
    .cmd_o(cmd), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .busy_o, .done_o, .timeout_o
  );

  uart_mode_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  uart_mode_seq_busif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni,
    .cmd_i(cmd), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o),
    .ack_i(bus_ack_i), .rdata_i(bus_rdata_i),
    .rsp_o(rsp), .rsp_data_o(rsp_data)
  );

endmodule

// File: rtl/uart_mode_seq_chk.sv
module uart_mode_seq_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REG_SHIFT = 2,
  parameter int unsigned MAX_POLLS = 255
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  import uart_mode_seq_pkg::*;

  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(IDX_FIFO) << REG_SHIFT;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IDX_STAT) << REG_SHIFT;

  int unsigned rd_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rd_cnt <= 0;
    else if (!busy_o && start_i)          rd_cnt <= 0;
    else if (bus_req_o && bus_ack_i && !bus_we_o) rd_cnt <= rd_cnt + 1;
  end

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  a_r3_flush_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == A_FIFO |->
      bus_wdata_o[FIFO_RXCLR_BIT] && bus_wdata_o[FIFO_TXCLR_BIT]);

  a_r1_reads_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> bus_addr_o == A_STAT);

  a_r6_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= MAX_POLLS);

  a_r6_timeout_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);

  a_r7_timeout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(timeout_o));

endmodule

bind uart_mode_seq uart_mode_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_SHIFT(REG_SHIFT), .MAX_POLLS(MAX_POLLS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_ack_i(bus_ack_i)
);

// File: tb/uart_mode_seq_test.sv
module uart_mode_seq_test;
  localparam int GUARD = 100;
  localparam int GAP   = 50;
  localparam int MAXP  = 255;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] mode_val_i = '0;
  logic [7:0] fifo_val_i = '0;
  logic       bus_ack_i = 1'b0;
  logic [7:0] bus_rdata_i = '0;
  logic       busy_o, done_o, timeout_o, bus_req_o, bus_we_o;
  logic [7:0] bus_addr_o, bus_wdata_o;

  always #10 clk_i = ~clk_i;

  uart_mode_seq #(
    .ADDR_W(8), .DATA_W(8), .REG_SHIFT(2),
    .GUARD_CYCLES(GUARD), .POLL_GAP_CYCLES(GAP), .MAX_POLLS(MAXP)
  ) uut (
    .clk_i, .rst_ni, .start_i, .mode_val_i, .fifo_val_i,
    .busy_o, .done_o, .timeout_o,
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_ack_i, .bus_rdata_i
  );

  int checks = 0, errors = 0, cyc = 0;
  int tr_n, poll_idx, fail_n, done_cnt, wait_left, cur_rise;
  logic prev_req = 1'b0;
  logic [7:0] held_addr, held_wdata;
  logic tr_we [512];
  logic [7:0] tr_addr [512];
  logic [7:0] tr_data [512];
  int tr_acc [512];
  int tr_rise [512];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bad_stat();
    logic [7:0] v = 8'($urandom);
    if ((v & 8'h21) == 8'h20) v = v | 8'h01;
    return v;
  endfunction

  function automatic logic [7:0] good_stat();
    return (8'($urandom) & 8'hDE) | 8'h20;
  endfunction

  // bus slave and monitor, on falling edges
  always @(negedge clk_i) begin
    cyc++;
    if (done_o) done_cnt++;
    if (bus_ack_i) begin
      bus_ack_i = 1'b0;
    end else if (bus_req_o) begin
      if (!prev_req) begin
        cur_rise   = cyc;
        wait_left  = $urandom_range(0, 3);
        held_addr  = bus_addr_o;
        held_wdata = bus_wdata_o;
      end
      if (wait_left == 0) begin
        chk(bus_addr_o == held_addr && bus_wdata_o == held_wdata,
            "R10 fields stable until ack", bus_addr_o, held_addr);
        bus_ack_i = 1'b1;
        if (tr_n < 512) begin
          tr_we[tr_n]   = bus_we_o;
          tr_addr[tr_n] = bus_addr_o;
          tr_data[tr_n] = bus_wdata_o;
          tr_acc[tr_n]  = cyc;
          tr_rise[tr_n] = cur_rise;
        end
        if (!bus_we_o) begin
          bus_rdata_i = (poll_idx < fail_n) ? bad_stat() : good_stat();
          poll_idx++;
        end
        tr_n++;
      end else begin
        wait_left--;
      end
    end
    prev_req = bus_req_o;
  end

  task automatic run_case(input logic [7:0] m, input logic [7:0] f,
                          input int fn, input bit inject);
    int exp_reads;
    tr_n = 0; poll_idx = 0; fail_n = fn; done_cnt = 0;
    exp_reads = (fn >= MAXP) ? MAXP : fn + 1;
    @(negedge clk_i);
    start_i = 1'b1; mode_val_i = m; fifo_val_i = f;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    chk(timeout_o == 1'b0, "R7 timeout cleared by start", timeout_o, 0);
    if (inject) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1; mode_val_i = ~m; fifo_val_i = ~f;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk_i);
    chk(busy_o == 1'b0, "R8 busy low with done", busy_o, 0);
    repeat (8) @(negedge clk_i);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    chk(tr_n == 2 + exp_reads, "R6 transfer count", tr_n, 2 + exp_reads);
    chk(tr_we[0] && tr_addr[0] == 8'h20, "R1 mode write first", tr_addr[0], 8'h20);
    chk(tr_data[0] == m, "R9 mode data kept", tr_data[0], m);
    chk(tr_we[1] && tr_addr[1] == 8'h08, "R1 fifo write second", tr_addr[1], 8'h08);
    chk(tr_data[1] == (f | 8'h06), "R3 flush bits", tr_data[1], f | 8'h06);
    chk(tr_rise[1] - tr_acc[0] == GUARD + 1, "R2 guard interval",
        tr_rise[1] - tr_acc[0], GUARD + 1);
    for (int i = 2; i < tr_n && i < 512; i++) begin
      chk(!tr_we[i] && tr_addr[i] == 8'h14, "R1 status read", tr_addr[i], 8'h14);
      chk(tr_rise[i] - tr_acc[i-1] == ((i == 2) ? 2 : GAP + 1), "R5 poll spacing",
          tr_rise[i] - tr_acc[i-1], (i == 2) ? 2 : GAP + 1);
    end
    chk(timeout_o == (fn >= MAXP), "R4 R6 timeout result", timeout_o, fn >= MAXP);
    repeat (20) @(negedge clk_i);
    chk(timeout_o == (fn >= MAXP), "R7 timeout holds", timeout_o, fn >= MAXP);
    chk(tr_n == 2 + exp_reads && !busy_o, "R9 no extra transfers", tr_n, 2 + exp_reads);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !timeout_o && !bus_req_o, "R11 reset state",
        {busy_o, done_o, timeout_o, bus_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_case(8'h07, 8'hA0, 0, 1'b0);
    run_case(8'h00, 8'hA1, 3, 1'b0);
    run_case(8'h03, 8'h00, 300, 1'b0);
    run_case(8'h05, 8'h41, 1, 1'b1);
    for (int k = 0; k < 6; k++)
      run_case(8'($urandom), 8'($urandom), $urandom_range(0, 10), k[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule